// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer that steers a multicycle 32-bit load/store processor datapath. Every instruction passes through a shared fetch cycle and a shared decode cycle. Its 6-bit opcode, taken from the instruction register, then chooses a short execution sequence. That sequence is an address calculation followed by a memory read and a register write-back, or by a memory write. It can also be an ALU operation followed by a register write-back, a compare-and-branch, or a jump. After each sequence the sequencer returns to fetch.

The next step depends only on the current step and the opcode. Each step drives one fixed pattern on the datapath control lines: memory strobes, the address source, the instruction register load, the PC loads, the PC source, the ALU operand selects, the ALU operation class, the register-file write and the two write-back selects. The control lines come straight from registers and so they carry no glitches. They always match the step that is currently held.

Top module: `mcf_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the sequencer goes to fetch. In the cycle after that edge the outputs show the fetch pattern.
- R2: Fetch drives mem_rd=1, addr_sel=0, ir_load=1, alu_a_sel=0, alu_b_sel=01, alu_class=00, pc_load=1 and pc_src=00. Decode always follows, whatever the opcode.
- R3: Decode drives alu_a_sel=0, alu_b_sel=11 and alu_class=00, and asserts no strobe.
- R4: After decode, the next step depends on the opcode. Load (100011) and store (101011) go to address calculation. Register-register (000000) goes to ALU execute, branch-equal (000100) to branch and jump (000010) to jump. Any other opcode goes back to fetch.
- R5: Address calculation drives alu_a_sel=1, alu_b_sel=10 and alu_class=00. A load opcode then leads to the memory read step and any other opcode leads to the memory write step.
- R6: The load memory read step drives mem_rd=1 and addr_sel=1 and is followed by load write-back. Load write-back drives rf_write=1, wb_sel=1 and rf_dst_sel=0 and is followed by fetch.
- R7: The memory write step drives mem_wr=1 and addr_sel=1 and is followed by fetch.
- R8: ALU execute drives alu_a_sel=1, alu_b_sel=00 and alu_class=10 and is followed by register write-back. Register write-back drives rf_write=1, rf_dst_sel=1 and wb_sel=0 and is followed by fetch.
- R9: Branch drives alu_a_sel=1, alu_b_sel=00, alu_class=01, pc_load_if_eq=1 and pc_src=01 and is followed by fetch.
- R10: Jump drives pc_load=1 and pc_src=10 and is followed by fetch.
- R11: In every step, each strobe that step does not name is 0 and each select it does not name is 0. The opcode has no effect outside decode and address calculation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address source: 0 PC, 1 ALU output register |
| ir_load | output | 1 | Instruction register load |
| pc_load | output | 1 | Unconditional PC load |
| pc_load_if_eq | output | 1 | PC load when the ALU reports equality |
| pc_src | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 extended immediate, 11 extended immediate shifted by 2 |
| alu_class | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| rf_write | output | 1 | Register file write |
| rf_dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| wb_sel | output | 1 | Write-back data: 0 ALU output register, 1 memory data register |

## Verification
The hardest situations to reach are the two opcode-driven forks. At both forks the opcode must hold a particular value in exactly the cycle in which the sequencer sits in decode or in address calculation, and only the ports show which cycle that is. The bench therefore presents a new opcode in every cycle from a sequence that mixes the five defined codes with undefined ones. Over many instructions the decode cycle sees every code, including an undefined one that sends the sequencer straight back to fetch. The address cycle receives load and store codes as well as codes that differ from the one seen in decode. The opcodes presented in every other cycle show that the opcode has no effect there.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

    typedef enum logic [3:0] {
        ST_FETCH  = 4'd0,
        ST_DECODE = 4'd1,
        ST_ADDR   = 4'd2,
        ST_LDRD   = 4'd3,
        ST_LDWB   = 4'd4,
        ST_STWR   = 4'd5,
        ST_RREX   = 4'd6,
        ST_RRWB   = 4'd7,
        ST_BEQ    = 4'd8,
        ST_JMP    = 4'd9
    } state_e;

    typedef struct packed {
        logic       mem_rd;
        logic       mem_wr;
        logic       addr_sel;
        logic       ir_load;
        logic       pc_load;
        logic       pc_load_if_eq;
        logic [1:0] pc_src;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic [1:0] alu_class;
        logic       rf_write;
        logic       rf_dst_sel;
        logic       wb_sel;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '0;

    // select codes
    localparam logic [1:0] PCS_ALU  = 2'b00;
    localparam logic [1:0] PCS_OUT  = 2'b01;
    localparam logic [1:0] PCS_JMP  = 2'b10;
    localparam logic [1:0] BSEL_REG = 2'b00;
    localparam logic [1:0] BSEL_FOUR = 2'b01;
    localparam logic [1:0] BSEL_IMM = 2'b10;
    localparam logic [1:0] BSEL_IMM4 = 2'b11;
    localparam logic [1:0] ALU_ADD  = 2'b00;
    localparam logic [1:0] ALU_SUB  = 2'b01;
    localparam logic [1:0] ALU_FUNC = 2'b10;

    typedef struct packed {
        state_e st;
        ctl_t   ctl;
    } seq_t;

endpackage

// File: rtl/mcf_dispatch.sv
module mcf_dispatch
    import mcf_pkg::*;
#(
    parameter int OPW = 6,
    parameter logic [OPW-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OPW-1:0] OP_STORE = 6'b101011,
    parameter logic [OPW-1:0] OP_RR    = 6'b000000,
    parameter logic [OPW-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OPW-1:0] OP_JMP   = 6'b000010
) (
    input  state_e         st_q,
    input  logic [OPW-1:0] opcode,
    output state_e         st_d
);
    localparam int NCLS = 5;

    // one-hot opcode class flags, built from a list of codes
    logic [OPW-1:0] codes [NCLS];
    logic [NCLS-1:0] hit;

    assign codes[0] = OP_LOAD;
    assign codes[1] = OP_STORE;
    assign codes[2] = OP_RR;
    assign codes[3] = OP_BEQ;
    assign codes[4] = OP_JMP;

    for (genvar g = 0; g < NCLS; g++) begin : g_match
        assign hit[g] = (opcode == codes[g]);
    end

    state_e from_decode;

    always_comb begin
        from_decode = ST_FETCH;
        if (hit[0] || hit[1]) from_decode = ST_ADDR;
        else if (hit[2])      from_decode = ST_RREX;
        else if (hit[3])      from_decode = ST_BEQ;
        else if (hit[4])      from_decode = ST_JMP;
    end

    always_comb begin
        unique case (st_q)
            ST_FETCH:  st_d = ST_DECODE;
            ST_DECODE: st_d = from_decode;
            ST_ADDR:   st_d = hit[0] ? ST_LDRD : ST_STWR;
            ST_LDRD:   st_d = ST_LDWB;
            ST_RREX:   st_d = ST_RRWB;
            default:   st_d = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcf_outdec.sv
module mcf_outdec
    import mcf_pkg::*;
(
    input  state_e st,
    output ctl_t   ctl
);
    always_comb begin
        ctl = CTL_IDLE;
        unique case (st)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_load   = 1'b1;
                ctl.alu_b_sel = BSEL_FOUR;
                ctl.alu_class = ALU_ADD;
                ctl.pc_load   = 1'b1;
                ctl.pc_src    = PCS_ALU;
            end
            ST_DECODE: begin
                ctl.alu_b_sel = BSEL_IMM4;
                ctl.alu_class = ALU_ADD;
            end
            ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_IMM;
                ctl.alu_class = ALU_ADD;
            end
            ST_LDRD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl.rf_write = 1'b1;
                ctl.wb_sel   = 1'b1;
            end
            ST_STWR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_RREX: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSEL_REG;
                ctl.alu_class = ALU_FUNC;
            end
            ST_RRWB: begin
                ctl.rf_write   = 1'b1;
                ctl.rf_dst_sel = 1'b1;
            end
            ST_BEQ: begin
                ctl.alu_a_sel     = 1'b1;
                ctl.alu_b_sel     = BSEL_REG;
                ctl.alu_class     = ALU_SUB;
                ctl.pc_load_if_eq = 1'b1;
                ctl.pc_src        = PCS_OUT;
            end
            ST_JMP: begin
                ctl.pc_load = 1'b1;
                ctl.pc_src  = PCS_JMP;
            end
            default: ctl = CTL_IDLE;
        endcase
    end

endmodule

// File: rtl/mcf_ctrl.sv
module mcf_ctrl
    import mcf_pkg::*;
#(
    parameter int OPW = 6,
    parameter logic [OPW-1:0] OP_LOAD  = 6'b100011,
    parameter logic [OPW-1:0] OP_STORE = 6'b101011,
    parameter logic [OPW-1:0] OP_RR    = 6'b000000,
    parameter logic [OPW-1:0] OP_BEQ   = 6'b000100,
    parameter logic [OPW-1:0] OP_JMP   = 6'b000010
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           addr_sel,
    output logic           ir_load,
    output logic           pc_load,
    output logic           pc_load_if_eq,
    output logic [1:0]     pc_src,
    output logic           alu_a_sel,
    output logic [1:0]     alu_b_sel,
    output logic [1:0]     alu_class,
    output logic           rf_write,
    output logic           rf_dst_sel,
    output logic           wb_sel
);
    seq_t   seq_d, seq_q;
    state_e st_next;
    ctl_t   ctl_next;
    ctl_t   ctl_rst;

    mcf_dispatch #(
        .OPW(OPW), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
        .OP_RR(OP_RR), .OP_BEQ(OP_BEQ), .OP_JMP(OP_JMP)
    ) u_dispatch (
        .st_q  (seq_q.st),
        .opcode(opcode),
        .st_d  (st_next)
    );

    mcf_outdec u_outdec_next (
        .st (st_next),
        .ctl(ctl_next)
    );

    mcf_outdec u_outdec_rst (
        .st (ST_FETCH),
        .ctl(ctl_rst)
    );

    always_comb begin
        seq_d.st  = st_next;
        seq_d.ctl = ctl_next;
        if (rst) begin
            seq_d.st  = ST_FETCH;
            seq_d.ctl = ctl_rst;
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign mem_rd        = seq_q.ctl.mem_rd;
    assign mem_wr        = seq_q.ctl.mem_wr;
    assign addr_sel      = seq_q.ctl.addr_sel;
    assign ir_load       = seq_q.ctl.ir_load;
    assign pc_load       = seq_q.ctl.pc_load;
    assign pc_load_if_eq = seq_q.ctl.pc_load_if_eq;
    assign pc_src        = seq_q.ctl.pc_src;
    assign alu_a_sel     = seq_q.ctl.alu_a_sel;
    assign alu_b_sel     = seq_q.ctl.alu_b_sel;
    assign alu_class     = seq_q.ctl.alu_class;
    assign rf_write      = seq_q.ctl.rf_write;
    assign rf_dst_sel    = seq_q.ctl.rf_dst_sel;
    assign wb_sel        = seq_q.ctl.wb_sel;

endmodule

// File: rtl/mcf_ctrl_chk.sv
module mcf_ctrl_chk #(
    parameter int OPW = 6,
    parameter logic [OPW-1:0] OP_LOAD = 6'b100011
) (
    input logic           clk,
    input logic           rst,
    input logic [OPW-1:0] opcode,
    input logic           mem_rd,
    input logic           mem_wr,
    input logic           addr_sel,
    input logic           ir_load,
    input logic           pc_load,
    input logic           pc_load_if_eq,
    input logic [1:0]     pc_src,
    input logic           alu_a_sel,
    input logic [1:0]     alu_b_sel,
    input logic [1:0]     alu_class,
    input logic           rf_write,
    input logic           rf_dst_sel,
    input logic           wb_sel
);
    // R2
    fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ir_load |=> (!ir_load && !mem_rd && alu_b_sel == 2'b11 && !alu_a_sel));

    // R5
    addr_load_fork_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_b_sel == 2'b10 && opcode == OP_LOAD) |=> (mem_rd && addr_sel));

    // R6
    load_read_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && addr_sel) |=> (rf_write && wb_sel && !rf_dst_sel));

    // R7
    store_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_load);

    // R8
    alu_exec_then_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_class == 2'b10) |=> (rf_write && rf_dst_sel && !wb_sel));

    // R9
    branch_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load_if_eq |=> ir_load);

    // R11
    excl_strobes_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr, rf_write, pc_load_if_eq}));

endmodule

bind mcf_ctrl mcf_ctrl_chk #(.OPW(OPW), .OP_LOAD(OP_LOAD)) u_chk (
    .clk(clk), .rst(rst), .opcode(opcode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
    .ir_load(ir_load), .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq),
    .pc_src(pc_src), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .alu_class(alu_class), .rf_write(rf_write), .rf_dst_sel(rf_dst_sel),
    .wb_sel(wb_sel)
);

// File: tb/tb_mcf_ctrl.sv
module tb_mcf_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b0;
    logic       mem_rd, mem_wr, addr_sel, ir_load, pc_load, pc_load_if_eq;
    logic [1:0] pc_src, alu_b_sel, alu_class;
    logic       alu_a_sel, rf_write, rf_dst_sel, wb_sel;

    int checks = 0;
    int errors = 0;
    int model_st = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mcf_ctrl dut (
        .clk(clk), .rst(rst), .opcode(opcode),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
        .ir_load(ir_load), .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq),
        .pc_src(pc_src), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_class(alu_class), .rf_write(rf_write), .rf_dst_sel(rf_dst_sel),
        .wb_sel(wb_sel)
    );

    // step numbering: 0 fetch, 1 decode, 2 addr, 3 load read, 4 load wb,
    // 5 store, 6 alu exec, 7 alu wb, 8 branch, 9 jump
    function automatic int next_step(int s, logic [5:0] op);
        if (s == 0) return 1;
        if (s == 1) begin
            if (op == 6'b100011 || op == 6'b101011) return 2;
            if (op == 6'b000000) return 6;
            if (op == 6'b000100) return 8;
            if (op == 6'b000010) return 9;
            return 0;
        end
        if (s == 2) return (op == 6'b100011) ? 3 : 5;
        if (s == 3) return 4;
        if (s == 6) return 7;
        return 0;
    endfunction

    // {mem_rd,mem_wr,addr_sel,ir_load,pc_load,pc_load_if_eq,pc_src,
    //  alu_a_sel,alu_b_sel,alu_class,rf_write,rf_dst_sel,wb_sel}
    function automatic logic [15:0] expect_vec(int s);
        case (s)
            0: return 16'b1_0_0_1_1_0_00_0_01_00_0_0_0;
            1: return 16'b0_0_0_0_0_0_00_0_11_00_0_0_0;
            2: return 16'b0_0_0_0_0_0_00_1_10_00_0_0_0;
            3: return 16'b1_0_1_0_0_0_00_0_00_00_0_0_0;
            4: return 16'b0_0_0_0_0_0_00_0_00_00_1_0_1;
            5: return 16'b0_1_1_0_0_0_00_0_00_00_0_0_0;
            6: return 16'b0_0_0_0_0_0_00_1_00_10_0_0_0;
            7: return 16'b0_0_0_0_0_0_00_0_00_00_1_1_0;
            8: return 16'b0_0_0_0_0_1_01_1_00_01_0_0_0;
            9: return 16'b0_0_0_0_1_0_10_0_00_00_0_0_0;
            default: return 16'h0;
        endcase
    endfunction

    function automatic string req_of(int s);
        case (s)
            0: return "R2/R11";
            1: return "R3/R4";
            2: return "R4/R5";
            3, 4: return "R6";
            5: return "R7";
            6, 7: return "R8";
            8: return "R9";
            9: return "R10";
            default: return "R11";
        endcase
    endfunction

    // reference model advances on the clock
    always @(posedge clk) begin
        if (rst) model_st <= 0;
        else     model_st <= next_step(model_st, opcode);
    end

    logic [5:0] op_pool [8];
    initial begin
        op_pool[0] = 6'b100011; op_pool[1] = 6'b101011;
        op_pool[2] = 6'b000000; op_pool[3] = 6'b000100;
        op_pool[4] = 6'b000010; op_pool[5] = 6'b001000;
        op_pool[6] = 6'b111111; op_pool[7] = 6'b100011;
    end

    task automatic compare(string tag);
        logic [15:0] got, exp;
        got = {mem_rd, mem_wr, addr_sel, ir_load, pc_load, pc_load_if_eq,
               pc_src, alu_a_sel, alu_b_sel, alu_class, rf_write, rf_dst_sel, wb_sel};
        exp = expect_vec(model_st);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s step=%0d actual=%b expected=%b", tag, model_st, got, exp);
        end
    endtask

    initial begin : stim
        int seed = 7;
        // reset phase, R1
        repeat (3) begin
            @(negedge clk);
            compare("R1");
        end
        rst = 1'b0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            compare(req_of(model_st));
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            opcode = op_pool[(seed >> 16) & 7];
        end
        // mid-run reset, R1
        rst = 1'b1;
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
        opcode = 6'b000010;
        @(negedge clk);
        compare("R2");
        @(negedge clk);
        compare("R3");
        @(negedge clk);
        compare("R10");
        done = 1'b1;
    end

    initial begin : watchdog
        int n = 0;
        while (!done && n < 100000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule